// File: doc/BRIEF.md
# Rotating Register Rename Unit

This block turns logical register numbers into physical register numbers for a register file where part of each register class rotates. Three classes are handled: general, floating-point and predicate. Each class holds its own rotation base. A loop branch pulses the rotate strobe of a class, and the base of that class steps down by one. After the step, a value that was reached through logical register X is reached through X+1. The value at the top of the rotating window reappears at the bottom of that window.

The floating-point and predicate windows have fixed bounds. The general window always begins at register 32. Its length is set at run time in groups of eight registers. The lookups are combinational and read the registered state. Rotate, clear and resize take effect at the next rising clock edge.

Top module: `rot_rename_unit`

## Requirements
- R1: After reset every rotation base is 0 and the general window length is 0. Every lookup then returns its own logical number.
- R2: A floating-point register L in 32..127 maps to 32 + ((L − 32 + B) mod 96), where B is the floating-point base.
- R3: A predicate register L in 16..63 maps to 16 + ((L − 16 + B) mod 48), where B is the predicate base.
- R4: The general window covers 32 .. 32+8·G−1, where G is the 4-bit `gr_groups` value. Any value above 12 acts as 12. Inside the window a register maps to 32 + ((L − 32 + B) mod 8G). When G is 0, every general register maps to itself.
- R5: A rotate strobe sampled at a clock edge lowers that class's base by one. After that edge, logical X+1 returns the physical number that logical X returned before the edge.
- R6: Rotating when the base is 0 wraps the base to window length − 1. After that edge, the lowest window register returns the physical number that the highest window register returned before the edge.
- R7: Registers outside a class's window map to themselves, whatever the base is.
- R8: A rotate of one class leaves the mapping of the other classes unchanged.
- R9: `rot_clear` sets all three bases to 0 at the next edge and wins over any rotate strobe in the same cycle.
- R10: A new general window length takes effect at the next edge. At that same edge the general base is set to 0, even if a general rotate is requested in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rot_clear | input | 1 | Sets all rotation bases to 0 |
| gr_rotate | input | 1 | Rotate strobe for the general class |
| fr_rotate | input | 1 | Rotate strobe for the floating-point class |
| pr_rotate | input | 1 | Rotate strobe for the predicate class |
| gr_groups | input | 4 | Length of the general window in groups of 8 (values above 12 act as 12) |
| gr_log | input | 7 | Logical general register number |
| gr_phys | output | 7 | Physical general register number |
| fr_log | input | 7 | Logical floating-point register number |
| fr_phys | output | 7 | Physical floating-point register number |
| pr_log | input | 6 | Logical predicate register number |
| pr_phys | output | 6 | Physical predicate register number |

## Verification
Directed sequences cover three cases. A single rotate is checked against the value seen one register lower before the edge, which tells a decrement from an increment. A rotate from base 0 separates correct wrapping from an off-by-one at the window edge. A lookup below the window shows whether the window bounds are checked. Further sequences cover a clear together with a rotate, a resize together with a rotate, and a `gr_groups` value of 15. These tell the priority order apart and show whether the clamp is applied. A long stretch of mixed random strobes and lookups is then compared every cycle against a modulo model. This catches cross-talk between the classes and arithmetic errors for large base values, where the sum must be reduced by the window length.

// File: rtl/rot_rename_pkg.sv
package rot_rename_pkg;
  localparam int GR_COUNT      = 128;
  localparam int FR_COUNT      = 128;
  localparam int PR_COUNT      = 64;
  localparam int GR_LO         = 32;
  localparam int GR_GROUP_SZ   = 8;
  localparam int GR_MAX_GROUPS = 12;
  localparam int FR_LO         = 32;
  localparam int FR_SIZE       = 96;
  localparam int PR_LO         = 16;
  localparam int PR_SIZE       = 48;

  localparam int GR_IDX_W  = $clog2(GR_COUNT);
  localparam int FR_IDX_W  = $clog2(FR_COUNT);
  localparam int PR_IDX_W  = $clog2(PR_COUNT);
  localparam int GRP_W     = $clog2(GR_MAX_GROUPS + 1);
  localparam int GRP_SHIFT = $clog2(GR_GROUP_SZ);
  localparam int MAX_SIZE  = (GR_MAX_GROUPS * GR_GROUP_SZ > FR_SIZE) ?
                             GR_MAX_GROUPS * GR_GROUP_SZ : FR_SIZE;
  localparam int BASE_W    = $clog2(MAX_SIZE + 1);
endpackage

// File: rtl/rot_base_ctr.sv
module rot_base_ctr #(
  parameter int BW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear_i,
  input  logic          rotate_i,
  input  logic          resize_i,
  input  logic [BW-1:0] size_i,
  output logic [BW-1:0] base_o
);
  logic [BW-1:0] base_q;
  logic [BW-1:0] base_d;
  logic          base_en;

  always_comb begin
    base_d  = base_q;
    base_en = clear_i | resize_i | rotate_i;
    if (clear_i || resize_i) begin
      base_d = '0;
    end else if (rotate_i && (size_i != '0)) begin
      base_d = (base_q == '0) ? (size_i - 1'b1) : (base_q - 1'b1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (base_en) begin
      base_q <= base_d;
    end
  end

  assign base_o = base_q;

  p_base_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i != '0) |-> (base_q < size_i));
  p_base_empty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (size_i == '0) |-> (base_q == '0));
  p_step_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate_i && !clear_i && !resize_i && size_i != '0 && base_q != '0)
    |=> (base_q == BW'($past(base_q) - 1'b1)));
  p_wrap_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate_i && !clear_i && !resize_i && size_i != '0 && base_q == '0)
    |=> (base_q == BW'($past(size_i) - 1'b1)));
  p_clear_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_i |=> (base_q == '0));
  p_resize_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    resize_i |=> (base_q == '0));
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate_i && !clear_i && !resize_i) |=> $stable(base_q));
endmodule

// File: rtl/rot_win_map.sv
module rot_win_map #(
  parameter int IW = 7,
  parameter int BW = 7,
  parameter int LO = 32
) (
  input  logic [BW-1:0] size_i,
  input  logic [BW-1:0] base_i,
  input  logic [IW-1:0] log_i,
  output logic [IW-1:0] phys_o
);
  localparam int SW = ((IW > BW) ? IW : BW) + 1;

  logic [SW-1:0] log_x;
  logic [SW-1:0] off;
  logic [SW-1:0] sum;
  logic [SW-1:0] wrapped;
  logic          in_win;

  always_comb begin
    log_x   = SW'(log_i);
    off     = log_x - SW'(LO);
    in_win  = (size_i != '0) && (log_x >= SW'(LO)) && (off < SW'(size_i));
    sum     = off + SW'(base_i);
    wrapped = (sum >= SW'(size_i)) ? (sum - SW'(size_i)) : sum;
    phys_o  = in_win ? IW'(wrapped + SW'(LO)) : log_i;
  end
endmodule

// File: rtl/rot_rename_unit.sv
module rot_rename_unit
  import rot_rename_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rot_clear,
  input  logic                gr_rotate,
  input  logic                fr_rotate,
  input  logic                pr_rotate,
  input  logic [GRP_W-1:0]    gr_groups,
  input  logic [GR_IDX_W-1:0] gr_log,
  output logic [GR_IDX_W-1:0] gr_phys,
  input  logic [FR_IDX_W-1:0] fr_log,
  output logic [FR_IDX_W-1:0] fr_phys,
  input  logic [PR_IDX_W-1:0] pr_log,
  output logic [PR_IDX_W-1:0] pr_phys
);
  localparam logic [BASE_W-1:0] FR_SIZE_V = BASE_W'(FR_SIZE);
  localparam logic [BASE_W-1:0] PR_SIZE_V = BASE_W'(PR_SIZE);

  logic [GRP_W-1:0]  grp_clamped;
  logic [BASE_W-1:0] gr_size_d;
  logic [BASE_W-1:0] gr_size_q;
  logic              gr_resize;
  logic [BASE_W-1:0] gr_base;
  logic [BASE_W-1:0] fr_base;
  logic [BASE_W-1:0] pr_base;

  always_comb begin
    grp_clamped = (gr_groups > GRP_W'(GR_MAX_GROUPS)) ? GRP_W'(GR_MAX_GROUPS) : gr_groups;
    gr_size_d   = BASE_W'(grp_clamped) << GRP_SHIFT;
    gr_resize   = (gr_size_d != gr_size_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gr_size_q <= '0;
    end else if (gr_resize) begin
      gr_size_q <= gr_size_d;
    end
  end

  rot_base_ctr #(.BW(BASE_W)) u_gr_base (
    .clk(clk), .rst_n(rst_n), .clear_i(rot_clear), .rotate_i(gr_rotate),
    .resize_i(gr_resize), .size_i(gr_size_q), .base_o(gr_base));
  rot_base_ctr #(.BW(BASE_W)) u_fr_base (
    .clk(clk), .rst_n(rst_n), .clear_i(rot_clear), .rotate_i(fr_rotate),
    .resize_i(1'b0), .size_i(FR_SIZE_V), .base_o(fr_base));
  rot_base_ctr #(.BW(BASE_W)) u_pr_base (
    .clk(clk), .rst_n(rst_n), .clear_i(rot_clear), .rotate_i(pr_rotate),
    .resize_i(1'b0), .size_i(PR_SIZE_V), .base_o(pr_base));

  rot_win_map #(.IW(GR_IDX_W), .BW(BASE_W), .LO(GR_LO)) u_gr_map (
    .size_i(gr_size_q), .base_i(gr_base), .log_i(gr_log), .phys_o(gr_phys));
  rot_win_map #(.IW(FR_IDX_W), .BW(BASE_W), .LO(FR_LO)) u_fr_map (
    .size_i(FR_SIZE_V), .base_i(fr_base), .log_i(fr_log), .phys_o(fr_phys));
  rot_win_map #(.IW(PR_IDX_W), .BW(BASE_W), .LO(PR_LO)) u_pr_map (
    .size_i(PR_SIZE_V), .base_i(pr_base), .log_i(pr_log), .phys_o(pr_phys));

  p_fr_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fr_log) < FR_LO) |-> (fr_phys == fr_log));
  p_pr_outside_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(pr_log) < PR_LO) |-> (pr_phys == pr_log));
  p_gr_inside_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((int'(gr_log) >= GR_LO) && (int'(gr_log) < GR_LO + int'(gr_size_q)))
    |-> ((int'(gr_phys) >= GR_LO) && (int'(gr_phys) < GR_LO + int'(gr_size_q))));
  p_gr_size_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(gr_size_q) <= GR_MAX_GROUPS * GR_GROUP_SZ);
endmodule

// File: tb/rot_rename_unit_bench.sv
`timescale 1ns/1ps
module rot_rename_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       rot_clear, gr_rotate, fr_rotate, pr_rotate;
  logic [3:0] gr_groups;
  logic [6:0] gr_log, gr_phys, fr_log, fr_phys;
  logic [5:0] pr_log, pr_phys;

  int n_chk = 0;
  int n_err = 0;
  int mg = 0, mf = 0, mp = 0, msz = 0;
  bit done = 0;
  int cap_a, cap_b, cap_c;

  always #2 clk = ~clk;

  rot_rename_unit u_rot_rename_unit (
    .clk(clk), .rst_n(rst_n), .rot_clear(rot_clear), .gr_rotate(gr_rotate),
    .fr_rotate(fr_rotate), .pr_rotate(pr_rotate), .gr_groups(gr_groups),
    .gr_log(gr_log), .gr_phys(gr_phys), .fr_log(fr_log), .fr_phys(fr_phys),
    .pr_log(pr_log), .pr_phys(pr_phys));

  function automatic int ref_map(int lg, int lo, int sz, int b);
    if (sz == 0 || lg < lo || lg >= lo + sz) return lg;
    return lo + ((lg - lo + b) % sz);
  endfunction

  task automatic chk(int got, int exp, string tag, string what);
    n_chk++;
    if (got != exp) begin
      n_err++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, got, exp);
    end
  endtask

  task automatic apply(bit clr, bit gro, bit fro, bit pro, int grp, int gl, int fl, int pl);
    @(negedge clk);
    rot_clear = clr; gr_rotate = gro; fr_rotate = fro; pr_rotate = pro;
    gr_groups = 4'(grp); gr_log = 7'(gl); fr_log = 7'(fl); pr_log = 6'(pl);
    #1;
    chk(int'(gr_phys), ref_map(gl, 32, msz, mg), "R4", "gr model");
    chk(int'(fr_phys), ref_map(fl, 32, 96, mf), "R2", "fr model");
    chk(int'(pr_phys), ref_map(pl, 16, 48, mp), "R3", "pr model");
  endtask

  task automatic tick;
    int nsz;
    @(posedge clk);
    nsz = ((int'(gr_groups) > 12) ? 12 : int'(gr_groups)) * 8;
    if (rot_clear) begin
      mg = 0; mf = 0; mp = 0;
    end else begin
      if (nsz != msz) mg = 0;
      else if (gr_rotate && msz != 0) mg = (mg + msz - 1) % msz;
      if (fr_rotate) mf = (mf + 95) % 96;
      if (pr_rotate) mp = (mp + 47) % 48;
    end
    msz = nsz;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_err++; n_chk++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; rot_clear = 0; gr_rotate = 0; fr_rotate = 0; pr_rotate = 0;
    gr_groups = 0; gr_log = 0; fr_log = 0; pr_log = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: identity after reset
    apply(0, 0, 0, 0, 0, 100, 40, 20);
    chk(int'(gr_phys), 100, "R1", "gr reset");
    chk(int'(fr_phys), 40, "R1", "fr reset");
    chk(int'(pr_phys), 20, "R1", "pr reset");
    tick;

    // R5: rotate shifts value to next register number
    apply(0, 0, 1, 0, 0, 0, 32, 16);
    cap_a = int'(fr_phys);
    tick;
    apply(0, 0, 0, 0, 0, 0, 33, 16);
    chk(int'(fr_phys), cap_a, "R5", "fr x+1 after rotate");
    tick;

    // R6: wrap from base 0, top to bottom
    apply(0, 0, 0, 1, 0, 0, 32, 63);
    cap_b = int'(pr_phys);
    tick;
    apply(0, 0, 0, 0, 0, 0, 32, 16);
    chk(int'(pr_phys), cap_b, "R6", "pr low after wrap");
    tick;
    apply(0, 0, 0, 0, 0, 0, 32, 63);
    chk(int'(pr_phys), 62, "R6", "pr top after wrap");
    tick;

    // R7: outside window identity with nonzero bases
    apply(0, 0, 0, 0, 0, 5, 7, 3);
    chk(int'(fr_phys), 7, "R7", "fr below window");
    chk(int'(pr_phys), 3, "R7", "pr below window");
    tick;

    // R8: only the general class rotates
    apply(0, 0, 0, 0, 4, 40, 50, 30);
    tick;
    apply(0, 0, 0, 0, 4, 40, 50, 30);
    cap_b = int'(fr_phys); cap_c = int'(pr_phys);
    tick;
    apply(0, 1, 0, 0, 4, 40, 50, 30);
    tick;
    apply(0, 0, 0, 0, 4, 40, 50, 30);
    chk(int'(fr_phys), cap_b, "R8", "fr unchanged");
    chk(int'(pr_phys), cap_c, "R8", "pr unchanged");
    chk(int'(gr_phys), 39, "R5", "gr rotate once size 32");
    tick;

    // R9: clear beats rotate
    apply(1, 1, 1, 1, 4, 32, 32, 16);
    tick;
    apply(0, 0, 0, 0, 4, 32, 32, 16);
    chk(int'(gr_phys), 32, "R9", "gr after clear");
    chk(int'(fr_phys), 32, "R9", "fr after clear");
    chk(int'(pr_phys), 16, "R9", "pr after clear");
    tick;

    // R10: resize beats rotate, value 15 clamps to 12 groups
    apply(0, 1, 0, 0, 4, 32, 32, 16);
    tick;
    apply(0, 1, 0, 0, 15, 32, 32, 16);
    tick;
    apply(0, 0, 0, 0, 15, 32, 32, 16);
    chk(int'(gr_phys), 32, "R10", "gr base zero after resize");
    tick;
    apply(0, 1, 0, 0, 15, 127, 32, 16);
    chk(int'(gr_phys), 127, "R4", "gr top in clamped window");
    tick;
    apply(0, 0, 0, 0, 15, 127, 32, 16);
    chk(int'(gr_phys), 126, "R4", "gr clamped window rotated");
    tick;
    apply(0, 0, 0, 0, 0, 50, 32, 16);
    tick;
    apply(0, 1, 0, 0, 0, 50, 32, 16);
    chk(int'(gr_phys), 50, "R4", "gr zero window identity");
    tick;

    // mixed random traffic against the model
    for (int i = 0; i < 600; i++) begin
      int grp;
      grp = (($urandom % 16) == 0) ? int'($urandom % 16) : int'(gr_groups);
      apply(($urandom % 40) == 0, ($urandom % 3) != 0, ($urandom % 2) == 0,
            ($urandom % 3) == 0, grp, int'($urandom % 128),
            int'($urandom % 128), int'($urandom % 64));
      tick;
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule